// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for each beat of a single memory burst. A one-cycle start pulse carries a column address, a burst-length select and an ordering select. From the next clock onward, the block drives one column address per cycle. Each address has a valid flag, and the final beat also raises a last flag.

Only the three low column bits are reordered. All higher bits are copied unchanged from the start address. Two orderings are available:

- **Sequential:** the two low bits count upward and wrap inside a group of four. For 8-beat bursts, bit 2 then flips so the other group of four is visited with the same low-bit pattern.
- **Interleaved:** each address is the start address XORed with the beat number.

A start pulse may arrive on the last beat of a burst. The next burst then follows with no idle cycle. A start pulse in the middle of a burst abandons that burst and begins the new one.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after it is released with no start pulse, `seq_vld` and `seq_end` are 0.
- R2: The cycle after a start pulse, `seq_vld` is 1 and `seq_col` equals the captured `st_col`.
- R3: With `st_ilv`=0 and `st_len8`=0, beat k shows low bits [1:0] equal to (start[1:0]+k) mod 4, for example start 2 gives 2,3,0,1.
- R4: With `st_ilv`=0 and `st_len8`=1, beat k shows bits [1:0] = (start[1:0]+k) mod 4 and bit 2 = start[2] XOR k[2], for example start 5 gives 5,6,7,4,1,2,3,0.
- R5: With `st_ilv`=1, beat k shows bits [2:0] = start[2:0] XOR k, for example start 6 with an 8-beat burst gives 6,7,4,5,2,3,0,1.
- R6: Bits above bit 2 of `seq_col` equal those of the start address on every beat, and for 4-beat bursts bit 2 also keeps its start value.
- R7: `seq_vld` stays 1 for exactly 4 beats (`st_len8`=0) or 8 beats (`st_len8`=1). `seq_end` is 1 only on the final beat. `seq_vld` falls the cycle after the final beat unless a new start arrives.
- R8: A start pulse during the final beat makes the next cycle show beat 0 of the new burst, with `seq_vld` held at 1.
- R9: A start pulse during a non-final beat discards the rest of the running burst, and the next cycle shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st | input | 1 | Start pulse for a new burst |
| st_col | input | COL_W | Starting column address |
| st_len8 | input | 1 | 1 selects 8 beats, 0 selects 4 beats |
| st_ilv | input | 1 | 1 selects interleaved, 0 selects sequential ordering |
| seq_vld | output | 1 | Current beat address is valid |
| seq_col | output | COL_W | Column address of the current beat |
| seq_end | output | 1 | Current beat is the last of the burst |

## Verification
The bench concentrates on four corner cases:

- **Sequential 8-beat starts in the upper group of four.** An adder that counted modulo 8 would wrap linearly instead of switching groups.
- **4-beat bursts with bit 2 set.** A design that let the beat counter reach bit 2 would corrupt the address.
- **Back-to-back starts on the final beat.** A one-cycle gap or a dropped burst shows up as a missing beat.
- **Restarts in mid-burst.** A stale beat counter would continue the old order.

Random starts, lengths and orderings fill in the rest, and every beat is compared against an independently computed address.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st,
  input  logic [COL_W-1:0] st_col,
  input  logic             st_len8,
  input  logic             st_ilv,
  output logic             seq_vld,
  output logic [COL_W-1:0] seq_col,
  output logic             seq_end
);

  logic [COL_W-1:0] base;
  logic [2:0]       beat;
  logic             len8, ilv, run;
  logic [1:0]       lo_sum;
  logic             b2_flip;
  logic [2:0]       lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      beat <= '0;
      base <= '0;
      len8 <= 1'b0;
      ilv  <= 1'b0;
    end else if (st) begin
      run  <= 1'b1;
      beat <= '0;
      base <= st_col;
      len8 <= st_len8;
      ilv  <= st_ilv;
    end else if (run) begin
      run  <= !seq_end;
      beat <= beat + 3'd1;
    end
  end

  assign lo_sum  = ilv ? (base[1:0] ^ beat[1:0]) : (base[1:0] + beat[1:0]);
  assign b2_flip = len8 & beat[2];
  assign lo      = {base[2] ^ b2_flip, lo_sum};

  assign seq_vld = run;
  assign seq_end = run && (beat == (len8 ? 3'd7 : 3'd3));
  assign seq_col = {base[COL_W-1:3], lo};

  // R7
  end_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |-> seq_vld);

  // R7
  hold_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_vld && !seq_end && !st) |=> seq_vld);

  // R7
  drop_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && !st) |=> !seq_vld);

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st |=> (seq_vld && seq_col == $past(st_col)));

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_vld && !seq_end && !st) |=> (seq_col[COL_W-1:3] == $past(seq_col[COL_W-1:3])));

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             st = 1'b0;
  logic [COL_W-1:0] st_col = '0;
  logic             st_len8 = 1'b0;
  logic             st_ilv = 1'b0;
  logic             seq_vld, seq_end;
  logic [COL_W-1:0] seq_col;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .st(st), .st_col(st_col), .st_len8(st_len8),
    .st_ilv(st_ilv), .seq_vld(seq_vld), .seq_col(seq_col), .seq_end(seq_end));

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] c, bit l8, bit il, int k);
    int s, r;
    s = int'(c[2:0]);
    if (il) r = l8 ? (s ^ k) : ((s & 4) | ((s & 3) ^ k));
    else    r = (((s & 3) + k) % 4) + (l8 ? ((s & 4) ^ (k & 4)) : (s & 4));
    return {c[COL_W-1:3], 3'(r)};
  endfunction

  task automatic check(string req, logic [COL_W+1:0] act, logic [COL_W+1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the negedge showing the final beat
  task automatic burst(logic [COL_W-1:0] c, bit l8, bit il, string req);
    int len;
    len = l8 ? 8 : 4;
    st = 1'b1; st_col = c; st_len8 = l8; st_ilv = il;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      st = 1'b0;
      check(req, {seq_vld, seq_end, seq_col}, {1'b1, (k == len - 1), exp_col(c, l8, il, k)});
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    check("R7", {seq_vld, seq_end}, 2'b00);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    check("R1", {seq_vld, seq_end}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {seq_vld, seq_end}, 2'b00);

    burst(10'h002, 0, 0, "R3");       idle_chk();
    burst(10'h0E6, 0, 0, "R6");       idle_chk();
    burst(10'h005, 1, 0, "R4");       idle_chk();
    burst(10'h3F7, 1, 0, "R4");       idle_chk();
    burst(10'h006, 1, 1, "R5");       idle_chk();
    burst(10'h15D, 0, 1, "R5 R6");    idle_chk();
    burst(10'h001, 0, 0, "R8");
    burst(10'h20C, 1, 1, "R8");
    burst(10'h0A3, 1, 0, "R8");       idle_chk();

    // R9: restart after two beats of a running burst
    st = 1'b1; st_col = 10'h044; st_len8 = 1'b1; st_ilv = 1'b0;
    @(negedge clk); st = 1'b0;
    @(negedge clk);
    burst(10'h1F1, 0, 1, "R9");       idle_chk();

    for (int i = 0; i < 300; i++) begin
      logic [COL_W-1:0] c;
      c = COL_W'($urandom);
      burst(c, 1'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 R7");
      if ($urandom_range(0, 2) == 0) idle_chk();
    end
    idle_chk();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule